// File: doc/BRIEF.md
# Dual-Issue Pair Steering Unit

This unit sits between decode and execute in a two-wide in-order pipeline. Each cycle it looks at two decoded instructions, an older slot A and a younger slot B, and decides how they reach two execution lanes. The lanes are not symmetric. Only lane 0 may carry a control-transfer instruction, meaning a conditional branch or either jump form. Execute forwards results fully into both lanes, so only hazards inside the pair are resolved here.

A pair that is free of conflicts issues side by side in program order. When the younger instruction is the only control transfer and the two are fully independent, the unit exchanges lanes so that the branch lands in lane 0. In every other conflict it splits the pair. The older instruction issues alone, the younger one is kept in a one-entry holding register, and it issues alone in lane 0 on the following cycle. Meanwhile the unit stalls the stage above it. A flush from a resolved mispredict clears the holding register and blanks both lanes in the same cycle.

Top module: `dual_issue_steer`

## Requirements
- R1: A valid independent pair with no control transfer puts A in lane 0 and B in lane 1. The young flag is 0 on lane 0 and 1 on lane 1 (young = 1 marks the later instruction of a pair issued together), and up_stall equals dn_stall.
- R2: Lane 1 never carries an instruction whose ctl input is 1. A pair whose only control transfer is A issues unchanged.
- R3: If B is a control transfer, A is not, neither reads the other's nonzero destination and they do not share a nonzero destination, lanes are exchanged. Lane 0 then carries B with young = 1 and lane 1 carries A with young = 0.
- R4: If B reads (through rs1 or rs2 with its use bit set) a nonzero rd that A writes, the pair splits. A issues alone in lane 0 with young = 0, and next cycle B issues alone in lane 0 with young = 0.
- R5: If both write the same nonzero rd, the pair splits as in R4.
- R6: If both are control transfers, the pair splits as in R4.
- R7: If B is a control transfer, A is not, and A reads B's nonzero rd, the lanes are not exchanged and the pair splits as in R4.
- R8: While a held instruction is pending, up_stall is 1 and the slot inputs are ignored. The held instruction is the only one issued, in lane 0.
- R9: With flush at 1, both lane valids are 0 in that same cycle and any held instruction is discarded. On the next cycle a new pair is handled as if no split had occurred.
- R10: With dn_stall at 1, up_stall is 1 and no state advances. A pending split is neither captured nor released, and the same lanes are shown again on the next cycle.
- R11: If only one slot is valid, that instruction issues alone in lane 0 with young = 0 and is never exchanged. If neither slot is valid, both lanes are invalid.
- R12: Register 0 never creates a dependency or a shared destination.
- R13: With SWAP_EN = 0, every case that R3 would exchange splits as in R4 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Mispredict flush from lane 0 |
| dn_stall | input | 1 | Execute cannot accept this cycle |
| up_stall | output | 1 | Hold the decode pair |
| a_valid | input | 1 | Older slot valid |
| a_ctl | input | 1 | Older slot is a control transfer |
| a_wr | input | 1 | Older slot writes rd |
| a_rd | input | RA_W | Older slot destination |
| a_r1u | input | 1 | Older slot reads rs1 |
| a_r1 | input | RA_W | Older slot rs1 |
| a_r2u | input | 1 | Older slot reads rs2 |
| a_r2 | input | RA_W | Older slot rs2 |
| a_pay | input | PAY_W | Older slot payload |
| b_valid | input | 1 | Younger slot valid |
| b_ctl | input | 1 | Younger slot is a control transfer |
| b_wr | input | 1 | Younger slot writes rd |
| b_rd | input | RA_W | Younger slot destination |
| b_r1u | input | 1 | Younger slot reads rs1 |
| b_r1 | input | RA_W | Younger slot rs1 |
| b_r2u | input | 1 | Younger slot reads rs2 |
| b_r2 | input | RA_W | Younger slot rs2 |
| b_pay | input | PAY_W | Younger slot payload |
| l0_valid | output | 1 | Lane 0 carries an instruction |
| l0_young | output | 1 | Lane 0 holds the later of a co-issued pair |
| l0_pay | output | PAY_W | Lane 0 payload |
| l1_valid | output | 1 | Lane 1 carries an instruction |
| l1_young | output | 1 | Lane 1 holds the later of a co-issued pair |
| l1_pay | output | PAY_W | Lane 1 payload |

## Verification
The lane outputs and up_stall follow the slot inputs, flush and dn_stall in the same cycle, because no register sits on that path. The held half of a split appears in the cycle after the rising edge that captured it, and it leaves after the next edge on which dn_stall is low. The bench drives inputs on the falling edge and samples a quarter period later, before the next rising edge. So each split is checked first in its issue cycle and again exactly one edge later. A sweep over every combination of valid, control, write and register fields with two-bit register numbers covers the pairing cases. Directed sequences cover stalls, flushes and the variant without exchange.

// File: rtl/dis_pkg.sv
package dis_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PAIR,
      SEL_SWAP,
      SEL_SPLIT,
      SEL_ONLY_A,
      SEL_ONLY_B,
      SEL_HELD
   } steer_e;

endpackage

// File: rtl/dis_hazard.sv
module dis_hazard #(
   parameter int RA_W = 5
) (
   input  logic            a_wr,
   input  logic [RA_W-1:0] a_rd,
   input  logic            a_r1u,
   input  logic [RA_W-1:0] a_r1,
   input  logic            a_r2u,
   input  logic [RA_W-1:0] a_r2,
   input  logic            b_wr,
   input  logic [RA_W-1:0] b_rd,
   input  logic            b_r1u,
   input  logic [RA_W-1:0] b_r1,
   input  logic            b_r2u,
   input  logic [RA_W-1:0] b_r2,
   output logic            raw,
   output logic            war,
   output logic            waw
);
   localparam logic [RA_W-1:0] REG_ZERO = '0;

   logic a_dst_live, b_dst_live;
   logic b_uses_a, a_uses_b;

   assign a_dst_live = a_wr && (a_rd != REG_ZERO);
   assign b_dst_live = b_wr && (b_rd != REG_ZERO);

   always_comb begin
      b_uses_a = (b_r1u && (b_r1 == a_rd)) || (b_r2u && (b_r2 == a_rd));
      a_uses_b = (a_r1u && (a_r1 == b_rd)) || (a_r2u && (a_r2 == b_rd));
   end

   assign raw = a_dst_live && b_uses_a;
   assign war = b_dst_live && a_uses_b;
   assign waw = a_dst_live && b_dst_live && (a_rd == b_rd);

endmodule

// File: rtl/dis_decide.sv
module dis_decide
   import dis_pkg::*;
#(
   parameter int SWAP_EN = 1
) (
   input  logic   flush,
   input  logic   held_v,
   input  logic   a_valid,
   input  logic   b_valid,
   input  logic   a_ctl,
   input  logic   b_ctl,
   input  logic   raw,
   input  logic   war,
   input  logic   waw,
   output steer_e sel
);
   logic swap_legal;
   logic want_swap;
   logic must_split;

   generate
      if (SWAP_EN != 0) begin : g_swap
         assign swap_legal = !war;
      end else begin : g_noswap
         assign swap_legal = 1'b0;
      end
   endgenerate

   assign want_swap  = b_ctl && !a_ctl;
   assign must_split = raw || waw || (a_ctl && b_ctl) || (want_swap && !swap_legal);

   always_comb begin
      sel = SEL_NONE;
      if (flush) begin
         sel = SEL_NONE;
      end else if (held_v) begin
         sel = SEL_HELD;
      end else begin
         unique case ({a_valid, b_valid})
            2'b11: begin
               if (must_split)     sel = SEL_SPLIT;
               else if (want_swap) sel = SEL_SWAP;
               else                sel = SEL_PAIR;
            end
            2'b10:   sel = SEL_ONLY_A;
            2'b01:   sel = SEL_ONLY_B;
            default: sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/dis_lane_mux.sv
module dis_lane_mux
   import dis_pkg::*;
#(
   parameter int PAY_W = 32
) (
   input  steer_e           sel,
   input  logic [PAY_W-1:0] a_pay,
   input  logic [PAY_W-1:0] b_pay,
   input  logic [PAY_W-1:0] h_pay,
   output logic             l0_valid,
   output logic             l0_young,
   output logic [PAY_W-1:0] l0_pay,
   output logic             l1_valid,
   output logic             l1_young,
   output logic [PAY_W-1:0] l1_pay
);
   localparam logic [PAY_W-1:0] PAY_IDLE = '0;

   always_comb begin
      l0_valid = 1'b0;
      l0_young = 1'b0;
      l0_pay   = PAY_IDLE;
      l1_valid = 1'b0;
      l1_young = 1'b0;
      l1_pay   = PAY_IDLE;
      unique case (sel)
         SEL_PAIR: begin
            l0_valid = 1'b1;
            l0_pay   = a_pay;
            l1_valid = 1'b1;
            l1_young = 1'b1;
            l1_pay   = b_pay;
         end
         SEL_SWAP: begin
            l0_valid = 1'b1;
            l0_young = 1'b1;
            l0_pay   = b_pay;
            l1_valid = 1'b1;
            l1_pay   = a_pay;
         end
         SEL_SPLIT, SEL_ONLY_A: begin
            l0_valid = 1'b1;
            l0_pay   = a_pay;
         end
         SEL_ONLY_B: begin
            l0_valid = 1'b1;
            l0_pay   = b_pay;
         end
         SEL_HELD: begin
            l0_valid = 1'b1;
            l0_pay   = h_pay;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dual_issue_steer.sv
module dual_issue_steer
   import dis_pkg::*;
#(
   parameter int PAY_W   = 32,
   parameter int RA_W    = 5,
   parameter int SWAP_EN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             dn_stall,
   output logic             up_stall,
   input  logic             a_valid,
   input  logic             a_ctl,
   input  logic             a_wr,
   input  logic [RA_W-1:0]  a_rd,
   input  logic             a_r1u,
   input  logic [RA_W-1:0]  a_r1,
   input  logic             a_r2u,
   input  logic [RA_W-1:0]  a_r2,
   input  logic [PAY_W-1:0] a_pay,
   input  logic             b_valid,
   input  logic             b_ctl,
   input  logic             b_wr,
   input  logic [RA_W-1:0]  b_rd,
   input  logic             b_r1u,
   input  logic [RA_W-1:0]  b_r1,
   input  logic             b_r2u,
   input  logic [RA_W-1:0]  b_r2,
   input  logic [PAY_W-1:0] b_pay,
   output logic             l0_valid,
   output logic             l0_young,
   output logic [PAY_W-1:0] l0_pay,
   output logic             l1_valid,
   output logic             l1_young,
   output logic [PAY_W-1:0] l1_pay
);
   generate
      if (PAY_W < 1) begin : g_bad_pay
         $error("dual_issue_steer: PAY_W must be at least 1");
      end
      if (RA_W < 1) begin : g_bad_ra
         $error("dual_issue_steer: RA_W must be at least 1");
      end
      if (SWAP_EN != 0 && SWAP_EN != 1) begin : g_bad_swap
         $error("dual_issue_steer: SWAP_EN must be 0 or 1");
      end
   endgenerate

   logic             held_v;
   logic [PAY_W-1:0] held_pay;
   logic             raw, war, waw;
   steer_e           sel;

   dis_hazard #(.RA_W(RA_W)) u_haz (
      .a_wr  (a_wr),  .a_rd (a_rd),
      .a_r1u (a_r1u), .a_r1 (a_r1),
      .a_r2u (a_r2u), .a_r2 (a_r2),
      .b_wr  (b_wr),  .b_rd (b_rd),
      .b_r1u (b_r1u), .b_r1 (b_r1),
      .b_r2u (b_r2u), .b_r2 (b_r2),
      .raw   (raw),   .war  (war),   .waw (waw)
   );

   dis_decide #(.SWAP_EN(SWAP_EN)) u_dec (
      .flush   (flush),
      .held_v  (held_v),
      .a_valid (a_valid),
      .b_valid (b_valid),
      .a_ctl   (a_ctl),
      .b_ctl   (b_ctl),
      .raw     (raw),
      .war     (war),
      .waw     (waw),
      .sel     (sel)
   );

   dis_lane_mux #(.PAY_W(PAY_W)) u_mux (
      .sel      (sel),
      .a_pay    (a_pay),
      .b_pay    (b_pay),
      .h_pay    (held_pay),
      .l0_valid (l0_valid),
      .l0_young (l0_young),
      .l0_pay   (l0_pay),
      .l1_valid (l1_valid),
      .l1_young (l1_young),
      .l1_pay   (l1_pay)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_v   <= 1'b0;
         held_pay <= '0;
      end else if (flush) begin
         held_v   <= 1'b0;
      end else if (!dn_stall) begin
         if (sel == SEL_SPLIT) begin
            held_v   <= 1'b1;
            held_pay <= b_pay;
         end else if (sel == SEL_HELD) begin
            held_v   <= 1'b0;
         end
      end
   end

   assign up_stall = !flush && (dn_stall || held_v);

endmodule

// File: rtl/dis_checker.sv
module dis_checker #(
   parameter int PAY_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             dn_stall,
   input logic             up_stall,
   input logic             a_valid,
   input logic             a_ctl,
   input logic             b_valid,
   input logic             b_ctl,
   input logic [PAY_W-1:0] b_pay,
   input logic             l0_valid,
   input logic             l0_young,
   input logic [PAY_W-1:0] l0_pay,
   input logic             l1_valid,
   input logic             l1_young
);
   logic split_seen;
   assign split_seen = a_valid && b_valid && l0_valid && !l1_valid && !up_stall && !flush;

   // R1: two lanes issued together always carry opposite age tags
   a_r1_age_distinct: assert property (@(posedge clk) disable iff (!rst_n)
      (l0_valid && l1_valid) |-> (l0_young != l1_young));

   // R2: lane 1 never receives a control transfer
   a_r2_lane1_young_noctl: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_valid && l1_young) |-> !b_ctl);
   a_r2_lane1_old_noctl: assert property (@(posedge clk) disable iff (!rst_n)
      (l1_valid && !l1_young) |-> !a_ctl);

   // R8: a split makes the next cycle stall upstream and show the held half in lane 0
   a_r8_split_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      split_seen |=> (flush || up_stall));
   a_r8_held_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      split_seen |=> (flush || (l0_valid && !l1_valid && l0_pay == $past(b_pay))));

   // R9: flush blanks both lanes now and leaves nothing held afterwards
   a_r9_flush_blank: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!l0_valid && !l1_valid));
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (flush || (up_stall == dn_stall)));

   // R10: a downstream stall always propagates upstream
   a_r10_stall_up: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_stall && !flush) |-> up_stall);

   // R11: a single valid slot never uses lane 1
   a_r11_single_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (!up_stall && !(a_valid && b_valid)) |-> !l1_valid);

endmodule

bind dual_issue_steer dis_checker #(.PAY_W(PAY_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .flush    (flush),
   .dn_stall (dn_stall),
   .up_stall (up_stall),
   .a_valid  (a_valid),
   .a_ctl    (a_ctl),
   .b_valid  (b_valid),
   .b_ctl    (b_ctl),
   .b_pay    (b_pay),
   .l0_valid (l0_valid),
   .l0_young (l0_young),
   .l0_pay   (l0_pay),
   .l1_valid (l1_valid),
   .l1_young (l1_young)
);

// File: tb/dual_issue_steer_test.sv
module dual_issue_steer_test;
   localparam int PW = 8;
   localparam int RW = 2;
   localparam logic [PW-1:0] PA = 8'hA5;
   localparam logic [PW-1:0] PB = 8'h3C;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, flush, dn_stall;
   logic a_valid, a_ctl, a_wr, a_r1u, a_r2u;
   logic b_valid, b_ctl, b_wr, b_r1u, b_r2u;
   logic [RW-1:0] a_rd, a_r1, a_r2, b_rd, b_r1, b_r2;
   logic [PW-1:0] a_pay, b_pay;
   logic up_stall, l0_valid, l0_young, l1_valid, l1_young;
   logic [PW-1:0] l0_pay, l1_pay;
   logic n_up_stall, n_l0_valid, n_l0_young, n_l1_valid, n_l1_young;
   logic [PW-1:0] n_l0_pay, n_l1_pay;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   dual_issue_steer #(.PAY_W(PW), .RA_W(RW), .SWAP_EN(1)) uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .dn_stall(dn_stall), .up_stall(up_stall),
      .a_valid(a_valid), .a_ctl(a_ctl), .a_wr(a_wr), .a_rd(a_rd), .a_r1u(a_r1u), .a_r1(a_r1),
      .a_r2u(a_r2u), .a_r2(a_r2), .a_pay(a_pay),
      .b_valid(b_valid), .b_ctl(b_ctl), .b_wr(b_wr), .b_rd(b_rd), .b_r1u(b_r1u), .b_r1(b_r1),
      .b_r2u(b_r2u), .b_r2(b_r2), .b_pay(b_pay),
      .l0_valid(l0_valid), .l0_young(l0_young), .l0_pay(l0_pay),
      .l1_valid(l1_valid), .l1_young(l1_young), .l1_pay(l1_pay));

   dual_issue_steer #(.PAY_W(PW), .RA_W(RW), .SWAP_EN(0)) uut_ns (
      .clk(clk), .rst_n(rst_n), .flush(flush), .dn_stall(dn_stall), .up_stall(n_up_stall),
      .a_valid(a_valid), .a_ctl(a_ctl), .a_wr(a_wr), .a_rd(a_rd), .a_r1u(a_r1u), .a_r1(a_r1),
      .a_r2u(a_r2u), .a_r2(a_r2), .a_pay(a_pay),
      .b_valid(b_valid), .b_ctl(b_ctl), .b_wr(b_wr), .b_rd(b_rd), .b_r1u(b_r1u), .b_r1(b_r1),
      .b_r2u(b_r2u), .b_r2(b_r2), .b_pay(b_pay),
      .l0_valid(n_l0_valid), .l0_young(n_l0_young), .l0_pay(n_l0_pay),
      .l1_valid(n_l1_valid), .l1_young(n_l1_young), .l1_pay(n_l1_pay));

   function automatic logic [31:0] mk(input logic st, input logic v0, input logic y0,
                                      input logic [PW-1:0] p0, input logic v1,
                                      input logic y1, input logic [PW-1:0] p1);
      return {11'b0, st, v0, y0, p0 & {PW{v0}}, v1, y1, p1 & {PW{v1}}};
   endfunction

   function automatic logic [31:0] got_main();
      return mk(up_stall, l0_valid, l0_young, l0_pay, l1_valid, l1_young, l1_pay);
   endfunction

   function automatic logic [31:0] got_ns();
      return mk(n_up_stall, n_l0_valid, n_l0_young, n_l0_pay, n_l1_valid, n_l1_young, n_l1_pay);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic set_a(input logic v, input logic c, input logic w, input logic [RW-1:0] rd,
                        input logic u1, input logic [RW-1:0] r1, input logic u2,
                        input logic [RW-1:0] r2);
      a_valid = v; a_ctl = c; a_wr = w; a_rd = rd;
      a_r1u = u1; a_r1 = r1; a_r2u = u2; a_r2 = r2; a_pay = PA;
   endtask

   task automatic set_b(input logic v, input logic c, input logic w, input logic [RW-1:0] rd,
                        input logic u1, input logic [RW-1:0] r1, input logic u2,
                        input logic [RW-1:0] r2);
      b_valid = v; b_ctl = c; b_wr = w; b_rd = rd;
      b_r1u = u1; b_r1 = r1; b_r2u = u2; b_r2 = r2; b_pay = PB;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      #5;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // canned vectors
   function automatic logic [31:0] v_pair();  return mk(0, 1, 0, PA, 1, 1, PB); endfunction
   function automatic logic [31:0] v_swap();  return mk(0, 1, 1, PB, 1, 0, PA); endfunction
   function automatic logic [31:0] v_onlya(); return mk(0, 1, 0, PA, 0, 0, 0);  endfunction
   function automatic logic [31:0] v_onlyb(); return mk(0, 1, 0, PB, 0, 0, 0);  endfunction
   function automatic logic [31:0] v_held();  return mk(1, 1, 0, PB, 0, 0, 0);  endfunction
   function automatic logic [31:0] v_none();  return mk(0, 0, 0, 0, 0, 0, 0);   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; flush = 1'b0; dn_stall = 1'b0;
      set_a(0, 0, 0, 0, 0, 0, 0, 0);
      set_b(0, 0, 0, 0, 0, 0, 0, 0);
      repeat (3) step();
      settle();
      chk("R11 reset idle", got_main(), v_none());
      step();
      rst_n = 1'b1;
      settle();
      chk("R11 after reset", got_main(), v_none());

      // sweep over every pairing field combination with rs2 unused
      for (int c = 0; c < 16384; c++) begin
         logic av, bv, ac, bc, aw, bw;
         logic [RW-1:0] ard, brd, ar1, br1;
         logic raw, war, waw, split, swap;
         string tag;
         av = c[0]; bv = c[1]; ac = c[2]; bc = c[3]; aw = c[4]; bw = c[5];
         ard = c[7:6]; brd = c[9:8]; ar1 = c[11:10]; br1 = c[13:12];
         step();
         set_a(av, ac, aw, ard, 1, ar1, 0, 0);
         set_b(bv, bc, bw, brd, 1, br1, 0, 0);
         raw = aw && (ard != 0) && (br1 == ard);
         war = bw && (brd != 0) && (ar1 == brd);
         waw = aw && bw && (ard != 0) && (ard == brd);
         split = av && bv && (raw || waw || (ac && bc) || (bc && !ac && war));
         swap  = av && bv && !split && bc && !ac;
         if (!av || !bv)          tag = "R11 single or empty";
         else if (raw)            tag = "R4 raw split";
         else if (waw)            tag = "R5 same rd split";
         else if (ac && bc)       tag = "R6 two branches split";
         else if (bc && war)      tag = "R7 swap blocked";
         else if (swap)           tag = "R3 swap";
         else if (aw && ard == 0 && (br1 == 0 || (bw && brd == 0))) tag = "R12 x0 pair";
         else if (ac)             tag = "R2 older branch pair";
         else                     tag = "R1 pair";
         settle();
         if (av && bv) begin
            if (split)     chk(tag, got_main(), v_onlya());
            else if (swap) chk(tag, got_main(), v_swap());
            else           chk(tag, got_main(), v_pair());
         end else if (av)  chk(tag, got_main(), v_onlya());
         else if (bv)      chk(tag, got_main(), v_onlyb());
         else              chk(tag, got_main(), v_none());
         if (split) begin
            step();
            settle();
            chk({tag, " R8 held next"}, got_main(), v_held());
         end
      end

      // R4 via rs2
      step();
      set_a(1, 0, 1, 2'd1, 0, 0, 0, 0);
      set_b(1, 0, 1, 2'd3, 0, 0, 1, 2'd1);
      settle();
      chk("R4 rs2 split", got_main(), v_onlya());
      // R8: replace inputs while held, they must be ignored
      step();
      set_a(1, 0, 1, 2'd2, 1, 2'd3, 0, 0);
      set_b(1, 0, 1, 2'd3, 1, 2'd3, 0, 0);
      a_pay = 8'h77; b_pay = 8'h66;
      settle();
      chk("R8 inputs ignored", got_main(), v_held());
      step();
      settle();
      chk("R8 new pair after held", got_main(), mk(0, 1, 0, 8'h77, 1, 1, 8'h66));

      // R9: flush with a held instruction
      step();
      set_a(1, 0, 1, 2'd1, 0, 0, 0, 0);
      set_b(1, 0, 0, 2'd0, 1, 2'd1, 0, 0);
      settle();
      chk("R9 split before flush", got_main(), v_onlya());
      step();
      flush = 1'b1;
      settle();
      chk("R9 flush blanks lanes", got_main(), v_none());
      step();
      flush = 1'b0;
      set_a(1, 0, 1, 2'd1, 1, 2'd2, 0, 0);
      set_b(1, 0, 1, 2'd3, 1, 2'd2, 0, 0);
      settle();
      chk("R9 held discarded", got_main(), v_pair());
      step();
      flush = 1'b1;
      settle();
      chk("R9 flush on pair", got_main(), v_none());
      flush = 1'b0;

      // R10: downstream stall freezes a split
      step();
      dn_stall = 1'b1;
      set_a(1, 0, 1, 2'd2, 0, 0, 0, 0);
      set_b(1, 0, 1, 2'd2, 0, 0, 0, 0);
      settle();
      chk("R10 stall on split", got_main(), mk(1, 1, 0, PA, 0, 0, 0));
      step();
      settle();
      chk("R10 split not captured", got_main(), mk(1, 1, 0, PA, 0, 0, 0));
      step();
      dn_stall = 1'b0;
      settle();
      chk("R10 split released", got_main(), v_onlya());
      step();
      dn_stall = 1'b1;
      settle();
      chk("R10 held under stall", got_main(), v_held());
      step();
      settle();
      chk("R10 held kept", got_main(), v_held());
      step();
      dn_stall = 1'b0;
      settle();
      chk("R10 held leaves", got_main(), v_held());
      step();
      set_a(1, 0, 1, 2'd1, 1, 2'd2, 0, 0);
      set_b(1, 0, 1, 2'd3, 1, 2'd2, 0, 0);
      settle();
      chk("R10 flow resumes", got_main(), v_pair());

      // R13: variant without exchange
      step();
      flush = 1'b1;
      step();
      flush = 1'b0;
      set_a(1, 0, 1, 2'd1, 1, 2'd2, 0, 0);
      set_b(1, 1, 1, 2'd3, 1, 2'd2, 0, 0);
      settle();
      chk("R3 swap in main", got_main(), v_swap());
      chk("R13 no-swap splits", got_ns(), v_onlya());
      step();
      set_a(0, 0, 0, 0, 0, 0, 0, 0);
      set_b(0, 0, 0, 0, 0, 0, 0, 0);
      settle();
      chk("R13 main idle", got_main(), v_none());
      chk("R13 no-swap held branch", got_ns(), v_held());
      step();
      settle();
      chk("R13 no-swap drained", got_ns(), v_none());

      done = 1'b1;
      summary();
      $finish;
   end

endmodule